// File: doc/BRIEF.md
# Inverted Page Table Walker

This block resolves a (process ID, virtual page) pair to a physical frame. It searches one system-wide table that holds a single slot per physical frame, so the table's size follows the amount of physical memory and not the size of the virtual address space. The request pair is hashed into a small bucket table. Each bucket holds the frame number of the first slot on its collision chain. The engine then walks that chain, one slot per clock, until a slot matches or the chain ends.

Both tables are register arrays inside the block. Software-side logic fills them through a single write port that selects either a bucket or a frame slot. A lookup is launched with a one-cycle request while the engine is idle. It finishes with a one-cycle `done` pulse, which carries a hit flag and the matching frame number. A miss means the page is not resident. The walk is capped at one visit per frame, so a damaged, looping chain still ends in a miss.

Top module: `ipt_walker`

## Requirements
- R1: While reset is held, `busy` and `done` are low. After reset every bucket is empty and every slot is invalid, so any lookup reports a miss.
- R2: The bucket index is formed in two steps. First, t = pid XOR vpn[PID_W-1:0]. Then t is zero-padded to a multiple of ANCHOR_W and its ANCHOR_W-bit slices are XORed together. With the defaults, this is t[3:0] ^ t[7:4].
- R3: A request is taken only in a cycle where `busy` is low. A request raised while `busy` is high is dropped: it changes neither the walk in progress nor any later output.
- R4: A hit is reported for the first slot on the chain that is valid and whose stored pid and vpn both equal the request. `frame` carries that slot's index.
- R5: A slot that is invalid, or whose pid or vpn differs from the request, is skipped. The walk continues at that slot's link.
- R6: Links and bucket entries are FRAME_W+1 bits wide, and a set MSB means null. A null bucket gives a miss without visiting any slot. A null link on a non-matching slot ends the walk with a miss.
- R7: Count the edge that takes the request as edge 0. If n slots are visited, `done` is high in the cycle after edge n, and `busy` is high in the cycles in between.
- R8: If no match is found after 2**FRAME_W slot visits, the walk ends with a miss, even when the chain loops.
- R9: A write with `cfg_tgt`=0 sets bucket `cfg_idx` to `cfg_link`. A write with `cfg_tgt`=1 sets slot `cfg_idx` to {`cfg_pid`, `cfg_vpn`, `cfg_link`, `cfg_valid`}. Later lookups use the new contents.
- R10: `done` lasts one cycle per lookup. On a miss, `frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tgt | input | 1 | 0 = bucket table, 1 = frame slot |
| cfg_idx | input | IDX_W | Bucket or slot index (low bits used) |
| cfg_pid | input | PID_W | Slot process ID |
| cfg_vpn | input | VPN_W | Slot virtual page |
| cfg_link | input | FRAME_W+1 | Bucket head or slot next link; MSB set = null |
| cfg_valid | input | 1 | Slot valid bit |
| req_valid | input | 1 | Lookup request |
| req_pid | input | PID_W | Requested process ID |
| req_vpn | input | VPN_W | Requested virtual page |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result pulse |
| hit | output | 1 | Result is resident |
| frame | output | FRAME_W | Matching frame index |

## Verification
The latency of a lookup depends on how many slots it visits. An empty bucket answers in the cycle after the request edge, and a chain with n visited slots answers in the cycle after edge n. A looping chain therefore answers 2**FRAME_W cycles after that. The bench model counts these visits itself from its own copy of the tables. It compares `busy`, `done`, `hit` and `frame` at every falling edge, so a result that arrives one cycle early or late is caught. Directed lookups also measure the request-to-done latency and compare it with a hand-computed value. They then confirm that `done` falls again in the following cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_STEP = 1'b1
  } walk_state_e;

  typedef enum logic {
    TGT_ANCHOR = 1'b0,
    TGT_ENTRY  = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W    = 8,
  parameter int VPN_W    = 20,
  parameter int ANCHOR_W = 4
) (
  input  logic [PID_W-1:0]    pid,
  input  logic [VPN_W-1:0]    vpn,
  output logic [ANCHOR_W-1:0] bucket
);
  localparam int NSLICE = (PID_W + ANCHOR_W - 1) / ANCHOR_W;
  localparam int PADW   = NSLICE * ANCHOR_W;

  logic [PID_W-1:0]    mixed;
  logic [PADW-1:0]     padded;
  logic [ANCHOR_W-1:0] acc [NSLICE+1];

  assign mixed  = pid ^ vpn[PID_W-1:0];
  assign padded = PADW'(mixed);
  assign acc[0] = '0;

  for (genvar g = 0; g < NSLICE; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ padded[g*ANCHOR_W +: ANCHOR_W];
  end

  assign bucket = acc[NSLICE];
endmodule

// File: rtl/ipt_anchor_tbl.sv
module ipt_anchor_tbl #(
  parameter int ANCHOR_W = 4,
  parameter int LINK_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ANCHOR_W-1:0] wr_idx,
  input  logic [LINK_W-1:0]   wr_link,
  input  logic [ANCHOR_W-1:0] rd_idx,
  output logic [LINK_W-1:0]   rd_link
);
  localparam int NANCHOR = 1 << ANCHOR_W;
  localparam logic [LINK_W-1:0] NULL_LINK = {1'b1, {(LINK_W-1){1'b0}}};

  logic [LINK_W-1:0] head_q [NANCHOR];

  for (genvar g = 0; g < NANCHOR; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == ANCHOR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   head_q[g] <= NULL_LINK;
      else if (sel) head_q[g] <= wr_link;
    end
  end

  assign rd_link = head_q[rd_idx];
endmodule

// File: rtl/ipt_entry_tbl.sv
module ipt_entry_tbl #(
  parameter int FRAME_W = 4,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int LINK_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_idx,
  input  logic [PID_W-1:0]   wr_pid,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [LINK_W-1:0]  wr_link,
  input  logic               wr_valid,
  input  logic [FRAME_W-1:0] rd_idx,
  output logic [PID_W-1:0]   rd_pid,
  output logic [VPN_W-1:0]   rd_vpn,
  output logic [LINK_W-1:0]  rd_link,
  output logic               rd_valid
);
  localparam int NFRAMES = 1 << FRAME_W;
  localparam logic [LINK_W-1:0] NULL_LINK = {1'b1, {(LINK_W-1){1'b0}}};

  logic [PID_W-1:0]  pid_q  [NFRAMES];
  logic [VPN_W-1:0]  vpn_q  [NFRAMES];
  logic [LINK_W-1:0] link_q [NFRAMES];
  logic              vld_q  [NFRAMES];

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    logic sel;
    assign sel = wr_en && (wr_idx == FRAME_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pid_q[g]  <= '0;
        vpn_q[g]  <= '0;
        link_q[g] <= NULL_LINK;
        vld_q[g]  <= 1'b0;
      end else if (sel) begin
        pid_q[g]  <= wr_pid;
        vpn_q[g]  <= wr_vpn;
        link_q[g] <= wr_link;
        vld_q[g]  <= wr_valid;
      end
    end
  end

  assign rd_pid   = pid_q[rd_idx];
  assign rd_vpn   = vpn_q[rd_idx];
  assign rd_link  = link_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/ipt_walk_ctrl.sv
module ipt_walk_ctrl
  import ipt_pkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int LINK_W  = FRAME_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [LINK_W-1:0]  head_link,
  output logic [FRAME_W-1:0] slot_idx,
  input  logic [PID_W-1:0]   slot_pid,
  input  logic [VPN_W-1:0]   slot_vpn,
  input  logic [LINK_W-1:0]  slot_link,
  input  logic               slot_valid,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic [FRAME_W-1:0] frame
);
  localparam int NFRAMES = 1 << FRAME_W;
  localparam logic [FRAME_W-1:0] LAST_STEP = FRAME_W'(NFRAMES - 1);

  walk_state_e        state_q, state_d;
  logic [FRAME_W-1:0] cur_q, cur_d;
  logic [FRAME_W-1:0] steps_q, steps_d;
  logic [PID_W-1:0]   pid_q;
  logic [VPN_W-1:0]   vpn_q;
  logic               done_q, done_d;
  logic               hit_q, hit_d;
  logic [FRAME_W-1:0] frame_q, frame_d;

  logic accept, head_null, match, chain_end, at_limit;

  assign accept    = (state_q == WALK_IDLE) && req_valid;
  assign head_null = head_link[LINK_W-1];
  assign match     = slot_valid && (slot_pid == pid_q) && (slot_vpn == vpn_q);
  assign chain_end = slot_link[LINK_W-1];
  assign at_limit  = (steps_q == LAST_STEP);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    steps_d = steps_q;
    done_d  = 1'b0;
    hit_d   = hit_q;
    frame_d = frame_q;
    unique case (state_q)
      WALK_IDLE: begin
        if (accept) begin
          if (head_null) begin
            done_d  = 1'b1;
            hit_d   = 1'b0;
            frame_d = '0;
          end else begin
            state_d = WALK_STEP;
            cur_d   = head_link[FRAME_W-1:0];
            steps_d = '0;
          end
        end
      end
      WALK_STEP: begin
        if (match) begin
          state_d = WALK_IDLE;
          done_d  = 1'b1;
          hit_d   = 1'b1;
          frame_d = cur_q;
        end else if (chain_end || at_limit) begin
          state_d = WALK_IDLE;
          done_d  = 1'b1;
          hit_d   = 1'b0;
          frame_d = '0;
        end else begin
          cur_d   = slot_link[FRAME_W-1:0];
          steps_d = steps_q + 1'b1;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      cur_q   <= '0;
      steps_q <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      steps_q <= steps_d;
      done_q  <= done_d;
      hit_q   <= hit_d;
      frame_q <= frame_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q <= '0;
      vpn_q <= '0;
    end else if (accept) begin
      pid_q <= req_pid;
      vpn_q <= req_vpn;
    end
  end

  assign slot_idx = cur_q;
  assign busy     = (state_q == WALK_STEP);
  assign done     = done_q;
  assign hit      = hit_q;
  assign frame    = frame_q;

  // R10: a result is never reported while a walk is still running
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: a miss carries frame 0
  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (frame == '0));

  // R3: a non-empty bucket at an idle request starts a walk
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !head_null) |=> busy);

  // R3: the captured request cannot change during a walk
  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pid_q) && $stable(vpn_q)));

  // R8: the final permitted visit without a match ends the walk
  assert_walk_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && at_limit && !match) |=> (!busy && done && !hit));

  // R4: a hit reports the slot that was being visited
  assert_hit_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && match) |=> (done && hit && frame == $past(slot_idx)));
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAME_W  = 4,
  parameter int ANCHOR_W = 4,
  parameter int PID_W    = 8,
  parameter int VPN_W    = 20,
  localparam int LINK_W  = FRAME_W + 1,
  localparam int IDX_W   = (FRAME_W > ANCHOR_W) ? FRAME_W : ANCHOR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_tgt,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [PID_W-1:0]   cfg_pid,
  input  logic [VPN_W-1:0]   cfg_vpn,
  input  logic [LINK_W-1:0]  cfg_link,
  input  logic               cfg_valid,
  input  logic               req_valid,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic [FRAME_W-1:0] frame
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                anc_we, ent_we;
  logic [ANCHOR_W-1:0] bucket;
  logic [LINK_W-1:0]   head_link;
  logic [FRAME_W-1:0]  slot_idx;
  logic [PID_W-1:0]    slot_pid;
  logic [VPN_W-1:0]    slot_vpn;
  logic [LINK_W-1:0]   slot_link;
  logic                slot_valid;

  assign anc_we = cfg_we && (cfg_tgt == logic'(TGT_ANCHOR));
  assign ent_we = cfg_we && (cfg_tgt == logic'(TGT_ENTRY));

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .ANCHOR_W(ANCHOR_W)) u_hash (
    .pid    (req_pid),
    .vpn    (req_vpn),
    .bucket (bucket)
  );

  ipt_anchor_tbl #(.ANCHOR_W(ANCHOR_W), .LINK_W(LINK_W)) u_anchor (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (anc_we),
    .wr_idx  (cfg_idx[ANCHOR_W-1:0]),
    .wr_link (cfg_link),
    .rd_idx  (bucket),
    .rd_link (head_link)
  );

  ipt_entry_tbl #(.FRAME_W(FRAME_W), .PID_W(PID_W), .VPN_W(VPN_W), .LINK_W(LINK_W)) u_entry (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (ent_we),
    .wr_idx   (cfg_idx[FRAME_W-1:0]),
    .wr_pid   (cfg_pid),
    .wr_vpn   (cfg_vpn),
    .wr_link  (cfg_link),
    .wr_valid (cfg_valid),
    .rd_idx   (slot_idx),
    .rd_pid   (slot_pid),
    .rd_vpn   (slot_vpn),
    .rd_link  (slot_link),
    .rd_valid (slot_valid)
  );

  ipt_walk_ctrl #(.FRAME_W(FRAME_W), .PID_W(PID_W), .VPN_W(VPN_W), .LINK_W(LINK_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_pid    (req_pid),
    .req_vpn    (req_vpn),
    .head_link  (head_link),
    .slot_idx   (slot_idx),
    .slot_pid   (slot_pid),
    .slot_vpn   (slot_vpn),
    .slot_link  (slot_link),
    .slot_valid (slot_valid),
    .busy       (busy),
    .done       (done),
    .hit        (hit),
    .frame      (frame)
  );

  // R1: outputs are quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!busy && !done);
    end
  end
endmodule

// File: tb/sim_ipt_walker.sv
`timescale 1ns/1ps
module sim_ipt_walker;
  localparam int NF = 16;
  localparam int NUL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_tgt = 1'b0, cfg_valid = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_pid = '0;
  logic [19:0] cfg_vpn = '0;
  logic [4:0]  cfg_link = '0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_pid = '0;
  logic [19:0] req_vpn = '0;
  logic        busy, done, hit;
  logic [3:0]  frame;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ipt_walker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_idx(cfg_idx),
    .cfg_pid(cfg_pid), .cfg_vpn(cfg_vpn), .cfg_link(cfg_link), .cfg_valid(cfg_valid),
    .req_valid(req_valid), .req_pid(req_pid), .req_vpn(req_vpn),
    .busy(busy), .done(done), .hit(hit), .frame(frame)
  );

  // mirror tables
  int m_anc [NF];
  int m_pid [NF];
  int m_vpn [NF];
  int m_lnk [NF];
  bit m_val [NF];

  function automatic int bucket_of(input int p, input int v);
    int t = (p ^ v) & 255;
    int h = 0;
    for (int i = 0; i < 8; i += 4) h ^= (t >> i) & 15;
    return h;
  endfunction

  task automatic walk(input int p, input int v, output int n, output bit h, output int f);
    int cur;
    n = 0; h = 0; f = 0;
    cur = m_anc[bucket_of(p, v)];
    if (cur >= NUL) return;
    for (int s = 0; s < NF; s++) begin
      n++;
      if (m_val[cur] && m_pid[cur] == p && m_vpn[cur] == v) begin
        h = 1; f = cur; return;
      end
      if (m_lnk[cur] >= NUL) return;
      cur = m_lnk[cur];
    end
  endtask

  // cycle model
  bit m_busy, m_done, m_hit, r_hit;
  int m_frame, r_frame, m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_hit <= 0; m_frame <= 0; m_rem <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (req_valid) begin
          int n; bit h; int f;
          walk(int'(req_pid), int'(req_vpn), n, h, f);
          if (n == 0) begin
            m_done <= 1; m_hit <= 0; m_frame <= 0;
          end else begin
            m_busy <= 1; m_rem <= n; r_hit <= h; r_frame <= f;
          end
        end
      end else begin
        if (m_rem == 1) begin
          m_busy <= 0; m_done <= 1; m_hit <= r_hit; m_frame <= r_frame;
        end
        m_rem <= m_rem - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (done !== m_done || busy !== m_busy) begin
        fails++;
        $display("FAIL R7 timing: done=%0b busy=%0b expected done=%0b busy=%0b", done, busy, m_done, m_busy);
      end
      if (m_done) begin
        checks++;
        if (hit !== m_hit || int'(frame) != m_frame) begin
          fails++;
          $display("FAIL R4 result: hit=%0b frame=%0d expected hit=%0b frame=%0d", hit, frame, m_hit, m_frame);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_anchor(input int idx, input int lnk);
    @(negedge clk);
    cfg_we = 1; cfg_tgt = 0; cfg_idx = 4'(idx); cfg_link = 5'(lnk);
    m_anc[idx] = lnk;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_slot(input int idx, input int p, input int v, input int lnk, input bit vld);
    @(negedge clk);
    cfg_we = 1; cfg_tgt = 1; cfg_idx = 4'(idx); cfg_pid = 8'(p); cfg_vpn = 20'(v);
    cfg_link = 5'(lnk); cfg_valid = vld;
    m_pid[idx] = p; m_vpn[idx] = v; m_lnk[idx] = lnk; m_val[idx] = vld;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic lookup(input int p, input int v, input bit eh, input int ef, input int el, input string tag);
    int lat;
    @(negedge clk);
    req_valid = 1; req_pid = 8'(p); req_vpn = 20'(v);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == el, tag, "latency", lat, el);
    check(hit == eh, tag, "hit", int'(hit), int'(eh));
    check(int'(frame) == ef, tag, "frame", int'(frame), ef);
    @(negedge clk);
    check(done == 1'b0, "R10", "done after pulse", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < NF; i++) begin
      m_anc[i] = NUL; m_pid[i] = 0; m_vpn[i] = 0; m_lnk[i] = NUL; m_val[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1", "busy|done in reset", int'(busy | done), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: empty tables miss straight away
    lookup(8'h12, 20'h00034, 0, 0, 1, "R1");
    // build chain on bucket 4: slot 5 -> slot 9 -> null (R9)
    wr_anchor(4, 5);
    wr_slot(5, 8'h12, 20'h00034, 9, 1);
    wr_slot(9, 8'h21, 20'h70025, NUL, 1);
    check(bucket_of(8'h21, 20'h70025) == 4, "R2", "bench bucket", bucket_of(8'h21, 20'h70025), 4);
    lookup(8'h12, 20'h00034, 1, 5, 2, "R4");
    lookup(8'h21, 20'h70025, 1, 9, 3, "R7");
    // R5/R6: same bucket, vpn differs only in high bits: walk to end, miss
    lookup(8'h21, 20'h00025, 0, 0, 3, "R6");
    // R5: invalid head is skipped
    wr_slot(5, 8'h12, 20'h00034, 9, 0);
    lookup(8'h12, 20'h00034, 0, 0, 3, "R5");
    lookup(8'h21, 20'h70025, 1, 9, 3, "R5");
    wr_slot(5, 8'h12, 20'h00034, 9, 1);
    // R2: bucket 0 from 0x21^0x65, bucket 3 ignores vpn high bits
    wr_anchor(0, 2);
    wr_slot(2, 8'h21, 20'h00065, NUL, 1);
    lookup(8'h21, 20'h00065, 1, 2, 2, "R2");
    wr_anchor(3, 7);
    wr_slot(7, 8'h03, 20'h12300, NUL, 1);
    lookup(8'h03, 20'h12300, 1, 7, 2, "R2");
    // R8: looping chain on bucket 6 (10 <-> 11)
    wr_anchor(6, 10);
    wr_slot(10, 8'h44, 20'h00001, 11, 1);
    wr_slot(11, 8'h45, 20'h00002, 10, 1);
    lookup(8'h06, 20'h00000, 0, 0, 17, "R8");
    // R3: request during a walk is dropped
    @(negedge clk);
    req_valid = 1; req_pid = 8'h06; req_vpn = 20'h0;
    @(negedge clk);
    req_pid = 8'h12; req_vpn = 20'h00034;
    repeat (3) @(negedge clk);
    req_valid = 0;
    begin
      int seen = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (done) begin
          seen++;
          check(hit == 1'b0, "R3", "walk result hit", int'(hit), 0);
        end
      end
      check(seen == 1, "R3", "done pulses", seen, 1);
    end
    // R9: re-point bucket 4 to slot 9, slot 5 no longer reached
    wr_anchor(4, 9);
    lookup(8'h12, 20'h00034, 0, 0, 2, "R9");
    wr_anchor(4, NUL);
    lookup(8'h21, 20'h70025, 0, 0, 1, "R6");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule